// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers single-cycle event pulses from four neighbouring sources (a real-time-clock periodic tick, a real-time-clock alarm, a real-time-clock update error and a push-button press) into a 16-bit word of sticky status flags. A 16-bit mask selects which flags may raise the single active-high interrupt line. Software finds out what happened by reading the status and clears flags by writing ones to a separate acknowledge register.

Status, mask and acknowledge are each split into a low byte (bits 7:0) and a high byte (bits 15:8). They are reached through a simple byte-wide register port with an address, a write strobe and a read strobe. Six consecutive addresses starting at a parameterised base hold the registers: mask low, mask high, status low, status high, acknowledge low and acknowledge high. At the default base these are 0x17 to 0x1C.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, status reads 0x00 at both bytes, mask reads 0xFF (low, 0x17) and 0x0F (high, 0x18), and the interrupt output is 0.
- R2: The interrupt output is a register. On each clock it takes the OR of (status AND NOT mask) as held before that edge, so it follows a status or mask change one clock later.
- R3: A write to 0x17 replaces mask bits 7:0 only. A write to 0x18 replaces mask bits 15:8 only.
- R4: A write to 0x1B clears each status bit 7:0 whose written bit is 1. A write to 0x1C does the same for bits 15:8. Zero bits leave status alone. Reads of 0x1B and 0x1C return 0x00.
- R5: Each event pulse sets one status bit: tick sets bit 8, alarm bit 9, update error bit 10 and push button bit 11. Status bits 7:0 read at 0x19 and bits 15:8 at 0x1A.
- R6: Status bits are sticky. A set bit stays set, whatever the mask, until an acknowledge write clears it.
- R7: When an event pulse and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R8: Writes to the status addresses 0x19 and 0x1A change nothing.
- R9: Read data appears on the read-data port one clock after the read strobe. Addresses outside the six registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W (8) | Register address |
| regWrEn | input | 1 | Write strobe, one cycle per byte |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 8 | Read data, valid the clock after regRdEn |
| evtTick | input | 1 | Periodic tick event pulse |
| evtAlarm | input | 1 | Alarm event pulse |
| evtRtcErr | input | 1 | Clock update error event pulse |
| evtButton | input | 1 | Push-button press event pulse |
| irqOut | output | 1 | Registered active-high interrupt |

## Verification
The assertions assume that the register strobes and the event inputs are sampled cleanly at rising edges. They also assume that no write or read is in flight during the first cycle after reset, because several properties reason about the previous cycle's address and data. The bench drives every input on the falling edge, holds each strobe and each event pulse for exactly one cycle, and keeps all of them low throughout reset. It deliberately lines up an event pulse with an acknowledge of the same bit so that the priority property is exercised.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int BYTE_W = 8;
  localparam int HALVES = 2;
  localparam int STAT_W = BYTE_W * HALVES;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_MASK = 2'd1,
    RD_STAT = 2'd2
  } rd_kind_e;

  // Strobes handed from the decoder to the datapath.
  typedef struct packed {
    logic [HALVES-1:0] maskWr;
    logic [HALVES-1:0] ackWr;
    logic              rdEn;
    rd_kind_e          rdKind;
    logic              rdHalf;
  } strobe_t;

endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 8'h17
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] A_MASK_LO = REG_BASE;
  localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(REG_BASE + 1);
  localparam logic [ADDR_W-1:0] A_STAT_LO = ADDR_W'(REG_BASE + 2);
  localparam logic [ADDR_W-1:0] A_STAT_HI = ADDR_W'(REG_BASE + 3);
  localparam logic [ADDR_W-1:0] A_ACK_LO  = ADDR_W'(REG_BASE + 4);
  localparam logic [ADDR_W-1:0] A_ACK_HI  = ADDR_W'(REG_BASE + 5);

  always_comb begin
    strb        = '0;
    strb.rdKind = RD_ZERO;
    strb.rdEn   = regRdEn;
    case (regAddr)
      A_MASK_LO: begin
        strb.maskWr[0] = regWrEn;
        strb.rdKind    = RD_MASK;
        strb.rdHalf    = 1'b0;
      end
      A_MASK_HI: begin
        strb.maskWr[1] = regWrEn;
        strb.rdKind    = RD_MASK;
        strb.rdHalf    = 1'b1;
      end
      A_STAT_LO: begin
        strb.rdKind = RD_STAT;
        strb.rdHalf = 1'b0;
      end
      A_STAT_HI: begin
        strb.rdKind = RD_STAT;
        strb.rdHalf = 1'b1;
      end
      A_ACK_LO: strb.ackWr[0] = regWrEn;
      A_ACK_HI: strb.ackWr[1] = regWrEn;
      default: ;
    endcase
  end

endmodule

// File: rtl/evt_irq_dp.sv
module evt_irq_dp
  import evt_irq_pkg::*;
#(
  parameter int                NUM_EVT  = 4,
  parameter int                EVT_BASE = 8,
  parameter logic [STAT_W-1:0] MASK_RST = 16'h0FFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic [NUM_EVT-1:0] evtVec,
  output logic [BYTE_W-1:0]  rdData,
  output logic [STAT_W-1:0]  statusVec,
  output logic [STAT_W-1:0]  maskVec,
  output logic               irq
);

  logic [BYTE_W-1:0] maskB [HALVES];
  logic [STAT_W-1:0] statusQ;
  logic [STAT_W-1:0] statusNext;
  logic [STAT_W-1:0] evtWide;

  // Mask: one byte register per half.
  for (genvar h = 0; h < HALVES; h++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskB[h] <= MASK_RST[h*BYTE_W +: BYTE_W];
      end else if (strb.maskWr[h]) begin
        maskB[h] <= wrData;
      end
    end
    assign maskVec[h*BYTE_W +: BYTE_W] = maskB[h];
  end

  // Place the event pulses at their status positions.
  always_comb begin
    evtWide = '0;
    evtWide[EVT_BASE +: NUM_EVT] = evtVec;
  end

  // Acknowledge clears first, then events set: events win.
  always_comb begin
    statusNext = statusQ;
    for (int h = 0; h < HALVES; h++) begin
      if (strb.ackWr[h]) begin
        statusNext[h*BYTE_W +: BYTE_W] = statusQ[h*BYTE_W +: BYTE_W] & ~wrData;
      end
    end
    statusNext = statusNext | evtWide;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= statusNext;
    end
  end

  // Interrupt follows the held status and mask one clock later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else begin
      irq <= |(statusQ & ~maskVec);
    end
  end

  // Registered read data.
  logic [BYTE_W-1:0] rdSel;
  always_comb begin
    case (strb.rdKind)
      RD_MASK: rdSel = strb.rdHalf ? maskVec[BYTE_W +: BYTE_W] : maskVec[0 +: BYTE_W];
      RD_STAT: rdSel = strb.rdHalf ? statusQ[BYTE_W +: BYTE_W] : statusQ[0 +: BYTE_W];
      default: rdSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      rdData <= rdSel;
    end
  end

  assign statusVec = statusQ;

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 8'h17,
  parameter int                EVT_BASE = 8,
  parameter logic [15:0]       MASK_RST = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              regRdEn,
  output logic [7:0]        regRdData,
  input  logic              evtTick,
  input  logic              evtAlarm,
  input  logic              evtRtcErr,
  input  logic              evtButton,
  output logic              irqOut
);

  localparam int NUM_EVT = 4;

  strobe_t           strb;
  logic [NUM_EVT-1:0] evtVec;
  logic [STAT_W-1:0] statusVec;
  logic [STAT_W-1:0] maskVec;

  assign evtVec = {evtButton, evtRtcErr, evtAlarm, evtTick};

  evt_irq_ctrl #(
    .ADDR_W  (ADDR_W),
    .REG_BASE(REG_BASE)
  ) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .strb   (strb)
  );

  evt_irq_dp #(
    .NUM_EVT (NUM_EVT),
    .EVT_BASE(EVT_BASE),
    .MASK_RST(MASK_RST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .evtVec   (evtVec),
    .rdData   (regRdData),
    .statusVec(statusVec),
    .maskVec  (maskVec),
    .irq      (irqOut)
  );

endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 8'h17
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic              regRdEn,
  input logic [7:0]        regRdData,
  input logic              evtTick,
  input logic              evtAlarm,
  input logic              evtRtcErr,
  input logic              evtButton,
  input logic              irqOut,
  input logic [15:0]       statusVec,
  input logic [15:0]       maskVec
);

  localparam logic [ADDR_W-1:0] A_MASK_LO = REG_BASE;
  localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(REG_BASE + 1);
  localparam logic [ADDR_W-1:0] A_STAT_LO = ADDR_W'(REG_BASE + 2);
  localparam logic [ADDR_W-1:0] A_STAT_HI = ADDR_W'(REG_BASE + 3);
  localparam logic [ADDR_W-1:0] A_ACK_LO  = ADDR_W'(REG_BASE + 4);
  localparam logic [ADDR_W-1:0] A_ACK_HI  = ADDR_W'(REG_BASE + 5);

  logic ackWrite;
  logic statWrite;
  logic anyEvt;
  assign ackWrite  = regWrEn && (regAddr == A_ACK_LO || regAddr == A_ACK_HI);
  assign statWrite = regWrEn && (regAddr == A_STAT_LO || regAddr == A_STAT_HI);
  assign anyEvt    = evtTick | evtAlarm | evtRtcErr | evtButton;

  // R2: interrupt lags the masked status by one clock.
  p_irq_lag_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |($past(statusVec) & ~$past(maskVec)));

  // R3: a low mask write keeps the high byte and loads the low byte.
  p_mask_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_MASK_LO) |=>
      (maskVec[15:8] == $past(maskVec[15:8]) && maskVec[7:0] == $past(regWrData)));

  // R3: a high mask write keeps the low byte and loads the high byte.
  p_mask_hi_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_MASK_HI) |=>
      (maskVec[7:0] == $past(maskVec[7:0]) && maskVec[15:8] == $past(regWrData)));

  // R4: acknowledge addresses read as zero.
  p_ack_reads_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && (regAddr == A_ACK_LO || regAddr == A_ACK_HI)) |=> regRdData == 8'h00);

  // R6: without an acknowledge, no status bit ever falls.
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ackWrite |=> ((statusVec & $past(statusVec)) == $past(statusVec)));

  // R5 and R7: a pulse always leaves its bit set, even under acknowledge.
  p_tick_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    evtTick |=> statusVec[8]);
  p_alarm_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    evtAlarm |=> statusVec[9]);
  p_err_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    evtRtcErr |=> statusVec[10]);
  p_button_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    evtButton |=> statusVec[11]);

  // R8: status writes without events leave status unchanged.
  p_status_ro_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && !anyEvt) |=> $stable(statusVec));

endmodule

bind evt_irq_hub evt_irq_hub_chk #(
  .ADDR_W  (ADDR_W),
  .REG_BASE(REG_BASE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdEn  (regRdEn),
  .regRdData(regRdData),
  .evtTick  (evtTick),
  .evtAlarm (evtAlarm),
  .evtRtcErr(evtRtcErr),
  .evtButton(evtButton),
  .irqOut   (irqOut),
  .statusVec(statusVec),
  .maskVec  (maskVec)
);

// File: tb/sim_evt_irq_hub.sv
`timescale 1ns/1ps
module sim_evt_irq_hub;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic       evtTick = 1'b0;
  logic       evtAlarm = 1'b0;
  logic       evtRtcErr = 1'b0;
  logic       evtButton = 1'b0;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  evt_irq_hub u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .evtTick(evtTick), .evtAlarm(evtAlarm), .evtRtcErr(evtRtcErr),
    .evtButton(evtButton), .irqOut(irqOut)
  );

  localparam logic [7:0] MASK_LO = 8'h17, MASK_HI = 8'h18;
  localparam logic [7:0] STAT_LO = 8'h19, STAT_HI = 8'h1A;
  localparam logic [7:0] ACK_LO  = 8'h1B, ACK_HI  = 8'h1C;

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  // Pulse events for one cycle: bit0 tick, bit1 alarm, bit2 error, bit3 button.
  task automatic pulse(input logic [3:0] e);
    @(negedge clk);
    {evtButton, evtRtcErr, evtAlarm, evtTick} = e;
    @(negedge clk);
    {evtButton, evtRtcErr, evtAlarm, evtTick} = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check8("R1", "irq after reset", {7'd0, irqOut}, 8'h00);
    rdReg(MASK_LO, d); check8("R1", "mask low", d, 8'hFF);
    rdReg(MASK_HI, d); check8("R1", "mask high", d, 8'h0F);
    rdReg(STAT_LO, d); check8("R1", "status low", d, 8'h00);
    rdReg(STAT_HI, d); check8("R1", "status high", d, 8'h00);
  endtask

  task automatic t_masked_sticky();
    logic [7:0] d;
    pulse(4'b0001);
    @(negedge clk);
    check8("R6", "irq stays low while masked", {7'd0, irqOut}, 8'h00);
    repeat (3) @(negedge clk);
    rdReg(STAT_HI, d); check8("R5", "tick sets bit 8", d, 8'h01);
  endtask

  task automatic t_unmask_timing();
    logic [7:0] d;
    wrReg(MASK_HI, 8'h0E);
    check8("R2", "irq not yet raised after mask write", {7'd0, irqOut}, 8'h00);
    @(negedge clk);
    check8("R2", "irq raised one clock later", {7'd0, irqOut}, 8'h01);
    rdReg(MASK_LO, d); check8("R3", "mask low untouched by high write", d, 8'hFF);
    rdReg(MASK_HI, d); check8("R3", "mask high loaded", d, 8'h0E);
  endtask

  task automatic t_all_sources();
    logic [7:0] d;
    pulse(4'b0010);
    pulse(4'b0100);
    pulse(4'b1000);
    rdReg(STAT_HI, d); check8("R5", "all four sources set", d, 8'h0F);
    rdReg(STAT_LO, d); check8("R5", "low status untouched", d, 8'h00);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    rdReg(ACK_LO, d); check8("R4", "ack low reads zero", d, 8'h00);
    rdReg(ACK_HI, d); check8("R4", "ack high reads zero", d, 8'h00);
    wrReg(ACK_LO, 8'hFF);
    rdReg(STAT_HI, d); check8("R4", "ack low leaves high byte", d, 8'h0F);
    wrReg(ACK_HI, 8'h05);
    check8("R2", "irq still high right after ack", {7'd0, irqOut}, 8'h01);
    @(negedge clk);
    check8("R2", "irq drops one clock after ack", {7'd0, irqOut}, 8'h00);
    rdReg(STAT_HI, d); check8("R4", "ack clears only ones", d, 8'h0A);
  endtask

  task automatic t_race();
    logic [7:0] d;
    @(negedge clk);
    regAddr = ACK_HI; regWrData = 8'h0F; regWrEn = 1'b1; evtTick = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; evtTick = 1'b0;
    rdReg(STAT_HI, d); check8("R7", "event beats same-cycle ack", d, 8'h01);
  endtask

  task automatic t_status_ro();
    logic [7:0] d;
    wrReg(STAT_HI, 8'h00);
    rdReg(STAT_HI, d); check8("R8", "write to status high ignored", d, 8'h01);
    wrReg(STAT_LO, 8'hFF);
    rdReg(STAT_LO, d); check8("R8", "write to status low ignored", d, 8'h00);
    check8("R8", "irq unchanged by status write", {7'd0, irqOut}, 8'h01);
  endtask

  task automatic t_mask_low_and_unmapped();
    logic [7:0] d;
    wrReg(MASK_LO, 8'hA5);
    rdReg(MASK_LO, d); check8("R3", "mask low loaded", d, 8'hA5);
    rdReg(MASK_HI, d); check8("R3", "mask high untouched by low write", d, 8'h0E);
    rdReg(8'h00, d); check8("R9", "unmapped 0x00 reads zero", d, 8'h00);
    rdReg(8'h40, d); check8("R9", "unmapped 0x40 reads zero", d, 8'h00);
    // R9: latency - issue read, data must hold previous value before the edge.
    @(negedge clk);
    regAddr = MASK_LO; regRdEn = 1'b1;
    #1 check8("R9", "read data not yet updated", regRdData, 8'h00);
    @(negedge clk);
    regRdEn = 1'b0;
    check8("R9", "read data one clock later", regRdData, 8'hA5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_sticky();
    t_unmask_timing();
    t_all_sources();
    t_ack();
    t_race();
    t_status_ro();
    t_mask_low_and_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule